// File: doc/BRIEF.md
# Packed-Lane Vector ALU with Per-Lane Condition Flags

This block is a 64-bit arithmetic unit that treats each operand as a group of packed lanes: eight 8-bit lanes, four 16-bit lanes, two 32-bit lanes or one 64-bit lane. The lane width is chosen per operation. Every lane is computed in parallel. The operations are add, subtract, greater-than compare, minimum, maximum, range clamp, flag-guarded move, and add-or-subtract steered by a flag. Saturating or wrapping arithmetic is chosen per operation, and so is signed or unsigned interpretation.

The unit holds eight four-bit condition flag sets, one for each possible lane position. An operation that carries the flag-write bit stores fresh flags for the lanes it used. Without that bit the stored flags stay as they were. The guarded move and the steered add-or-subtract read the stored flag of their own lane, so branchy per-element code can stay in vector form. Results and flags appear one clock after issue.

Top module: `simd_subword_alu`

## Requirements
- R1: `width_i` selects the lane width: 0 gives 8 bits, 1 gives 16, 2 gives 32 and 3 gives 64. Lane k occupies operand bits [k*W+W-1 : k*W], and there are 64/W lanes.
- R2: An operation issued with `valid_i` high in one cycle raises `valid_o` and shows its result on `res_o` in the next cycle. `valid_o` is low in a cycle that follows no issue.
- R3: Opcode 0 (add) and opcode 1 (subtract, a-b) wrap modulo 2^W per lane when `sat_i` is 0.
- R4: With `sat_i` set, add, subtract and add-or-subtract clamp each lane. With `signed_i` set the range is [-2^(W-1), 2^(W-1)-1]; otherwise it is [0, 2^W-1].
- R5: Opcode 2 (compare) writes all ones to a lane where a > b, and zero elsewhere. The comparison is signed when `signed_i` is set and unsigned otherwise.
- R6: Opcode 3 returns the lane-wise minimum of a and b, and opcode 4 returns the maximum, using the chosen signedness.
- R7: Opcode 5 (clamp) returns min(max(a, b), c) per lane, with b as the low bound and c as the high bound. When b > c the result is c.
- R8: The stored flags change only on a cycle with `valid_i` and `setf_i` both high. Such an operation rewrites flag sets 0 to 64/W-1 and leaves the higher sets unchanged.
- R9: Flag set k sits at `flags_o[4k+3:4k]`. Bit 0 is result-zero and bit 1 is the result's top bit. Bit 2 is the carry out of a+b (add) or a+~b+1 (subtract), and it is 0 for non-arithmetic opcodes. Bit 3 is a > b under the chosen signedness.
- R10: Opcode 6 (guarded move) returns lane b where stored flag bit `fsel_i` of that lane's set is 1, and lane a otherwise.
- R11: Opcode 7 returns a+b in lanes whose stored flag bit `fsel_i` is 1 and a-b in the other lanes. Saturation follows R4.
- R12: While `rst_n` is low at a clock edge, `valid_o`, `res_o` and every stored flag are cleared to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| valid_i | input | 1 | Issue an operation this cycle |
| op_i | input | 3 | Opcode 0..7 |
| width_i | input | 2 | Lane width code |
| sat_i | input | 1 | Saturating arithmetic |
| signed_i | input | 1 | Signed interpretation |
| setf_i | input | 1 | Permission to write the flags |
| fsel_i | input | 2 | Flag bit read by opcodes 6 and 7 |
| a_i | input | 64 | Operand a, also the destination's old value for the guarded move |
| b_i | input | 64 | Operand b, also the clamp low bound |
| c_i | input | 64 | Clamp high bound |
| valid_o | output | 1 | Result valid |
| res_o | output | 64 | Registered result |
| flags_o | output | 32 | Stored flags, four bits per set |

## Verification
The checker watches several properties on every cycle. It checks the one-cycle valid pipeline and that flags hold whenever the write bit is absent. It also checks that an 8-bit compare yields only 00 or FF bytes, that a 64-bit unsigned maximum is never below either input, and that a 64-bit guarded move returns one of its two inputs. Exact lane values cannot be judged from these invariants. These include saturation bounds, clamp ordering when the bounds cross, which flag sets survive a narrow-lane write, and the flag-driven choice of move or add-or-subtract. The bench scenarios check these against its own lane model through a result queue.

// File: rtl/simd_pkg.sv
// Package: shared opcode encoding and flag layout for the packed-lane ALU.
// Assumes four flag bits per lane set, in the bit order listed below.
package simd_pkg;

    typedef enum logic [2:0] {
        OP_ADD    = 3'd0,
        OP_SUB    = 3'd1,
        OP_CMP    = 3'd2,
        OP_MIN    = 3'd3,
        OP_MAX    = 3'd4,
        OP_CLIP   = 3'd5,
        OP_CMOV   = 3'd6,
        OP_ADDSUB = 3'd7
    } simd_op_e;

    localparam int FLAG_BITS = 4;
    localparam int FLG_ZERO  = 0;
    localparam int FLG_NEG   = 1;
    localparam int FLG_CARRY = 2;
    localparam int FLG_GT    = 3;

endpackage

// File: rtl/simd_lane.sv
// Module: one lane of the ALU, purely combinational.
// Computes the result and the four candidate flags of a LANE_W-bit lane.
// Assumes cflag is already the selected stored flag of this lane.
module simd_lane
    import simd_pkg::*;
#(
    parameter int LANE_W = 8
) (
    input  simd_op_e              op,
    input  logic                  sat,
    input  logic                  sgn,
    input  logic                  cflag,
    input  logic [LANE_W-1:0]     a,
    input  logic [LANE_W-1:0]     b,
    input  logic [LANE_W-1:0]     c,
    output logic [LANE_W-1:0]     res,
    output logic [FLAG_BITS-1:0]  flags
);
    localparam int MSB = LANE_W - 1;

    // Greater-than under signed or unsigned view: flip the top bit for signed.
    function automatic logic gt_f(input logic [LANE_W-1:0] x,
                                  input logic [LANE_W-1:0] y,
                                  input logic s);
        return {x[MSB] ^ s, x[MSB-1:0]} > {y[MSB] ^ s, y[MSB-1:0]};
    endfunction

    logic              sub_eff;
    logic              is_arith;
    logic [LANE_W-1:0] b_eff;
    logic [LANE_W:0]   sum;
    logic              ovf_s;
    logic [LANE_W-1:0] arith_r;
    logic              a_gt_b;
    logic [LANE_W-1:0] clip_t;
    logic [LANE_W-1:0] clip_r;

    // Shared adder with saturation; subtract is a + ~b + 1.
    always_comb begin
        sub_eff  = (op == OP_SUB) || ((op == OP_ADDSUB) && !cflag);
        is_arith = (op == OP_ADD) || (op == OP_SUB) || (op == OP_ADDSUB);
        b_eff    = sub_eff ? ~b : b;
        sum      = {1'b0, a} + {1'b0, b_eff} + {{LANE_W{1'b0}}, sub_eff};
        ovf_s    = (a[MSB] == b_eff[MSB]) && (sum[MSB] != a[MSB]);
        arith_r  = sum[MSB:0];
        if (sat) begin
            if (sgn) begin
                if (ovf_s) begin
                    arith_r = a[MSB] ? {1'b1, {MSB{1'b0}}} : {1'b0, {MSB{1'b1}}};
                end
            end else if (!sub_eff && sum[LANE_W]) begin
                arith_r = '1;
            end else if (sub_eff && !sum[LANE_W]) begin
                arith_r = '0;
            end
        end
    end

    // Comparisons feeding compare, min, max and clamp.
    always_comb begin
        a_gt_b = gt_f(a, b, sgn);
        clip_t = gt_f(b, a, sgn) ? b : a;
        clip_r = gt_f(clip_t, c, sgn) ? c : clip_t;
    end

    // Result select by opcode.
    always_comb begin
        case (op)
            OP_CMP:  res = {LANE_W{a_gt_b}};
            OP_MIN:  res = a_gt_b ? b : a;
            OP_MAX:  res = a_gt_b ? a : b;
            OP_CLIP: res = clip_r;
            OP_CMOV: res = cflag ? b : a;
            default: res = arith_r;
        endcase
    end

    // Candidate flags derived from the lane result and operands.
    always_comb begin
        flags            = '0;
        flags[FLG_ZERO]  = (res == '0);
        flags[FLG_NEG]   = res[MSB];
        flags[FLG_CARRY] = is_arith && sum[LANE_W];
        flags[FLG_GT]    = a_gt_b;
    end

endmodule

// File: rtl/simd_lane_bank.sv
// Module: all lanes of one fixed width, replicated across the data word.
// Assumes DATA_W is a multiple of LANE_W.
module simd_lane_bank
    import simd_pkg::*;
#(
    parameter int DATA_W = 64,
    parameter int LANE_W = 8,
    localparam int N_LANES = DATA_W / LANE_W
) (
    input  simd_op_e                      op,
    input  logic                          sat,
    input  logic                          sgn,
    input  logic [N_LANES-1:0]            cond,
    input  logic [DATA_W-1:0]             a,
    input  logic [DATA_W-1:0]             b,
    input  logic [DATA_W-1:0]             c,
    output logic [DATA_W-1:0]             res,
    output logic [N_LANES*FLAG_BITS-1:0]  flags
);
    // One lane unit per lane position.
    for (genvar k = 0; k < N_LANES; k++) begin : g_lane
        simd_lane #(.LANE_W(LANE_W)) u_lane (
            .op    (op),
            .sat   (sat),
            .sgn   (sgn),
            .cflag (cond[k]),
            .a     (a[k*LANE_W +: LANE_W]),
            .b     (b[k*LANE_W +: LANE_W]),
            .c     (c[k*LANE_W +: LANE_W]),
            .res   (res[k*LANE_W +: LANE_W]),
            .flags (flags[k*FLAG_BITS +: FLAG_BITS])
        );
    end

endmodule

// File: rtl/simd_flag_regs.sv
// Module: stored condition flags, one set per lane position.
// Assumes lane_en marks which sets the current write may change.
module simd_flag_regs
    import simd_pkg::*;
#(
    parameter int N_SETS = 8
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         we,
    input  logic [N_SETS-1:0]            lane_en,
    input  logic [N_SETS*FLAG_BITS-1:0]  d,
    output logic [N_SETS*FLAG_BITS-1:0]  q
);
    // Per-set write: only enabled sets take new flags on a permitted write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else if (we) begin
            for (int k = 0; k < N_SETS; k++) begin
                if (lane_en[k]) begin
                    q[k*FLAG_BITS +: FLAG_BITS] <= d[k*FLAG_BITS +: FLAG_BITS];
                end
            end
        end
    end

endmodule

// File: rtl/simd_subword_alu.sv
// Module: top of the packed-lane ALU. Builds one lane bank per lane width,
// picks the bank named by width_i, registers result and valid, and feeds
// the stored flags back to the guarded opcodes.
// Assumes MIN_LANE_W divides DATA_W and there are four lane widths.
module simd_subword_alu
    import simd_pkg::*;
#(
    parameter int DATA_W     = 64,
    parameter int MIN_LANE_W = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 valid_i,
    input  logic [2:0]           op_i,
    input  logic [1:0]           width_i,
    input  logic                 sat_i,
    input  logic                 signed_i,
    input  logic                 setf_i,
    input  logic [1:0]           fsel_i,
    input  logic [DATA_W-1:0]    a_i,
    input  logic [DATA_W-1:0]    b_i,
    input  logic [DATA_W-1:0]    c_i,
    output logic                 valid_o,
    output logic [DATA_W-1:0]    res_o,
    output logic [(DATA_W/MIN_LANE_W)*4-1:0] flags_o
);
    localparam int MAX_LANES  = DATA_W / MIN_LANE_W;
    localparam int NUM_WIDTHS = $clog2(MAX_LANES) + 1;
    localparam int FLAG_W     = MAX_LANES * FLAG_BITS;

    simd_op_e              op;
    logic [FLAG_W-1:0]     flag_q;
    logic [MAX_LANES-1:0]  cond_sel;
    logic [MAX_LANES-1:0]  lane_en;
    logic [DATA_W-1:0]     bank_res [NUM_WIDTHS];
    logic [FLAG_W-1:0]     bank_flg [NUM_WIDTHS];
    logic [DATA_W-1:0]     res_mux;
    logic [FLAG_W-1:0]     flg_mux;
    logic                  valid_q;
    logic [DATA_W-1:0]     res_q;

    assign op = simd_op_e'(op_i);

    // Pick each lane's guarding flag bit from its stored set.
    always_comb begin
        for (int k = 0; k < MAX_LANES; k++) begin
            cond_sel[k] = flag_q[k*FLAG_BITS + int'(fsel_i)];
        end
    end

    // Mark the flag sets that the active lane width covers.
    always_comb begin
        for (int k = 0; k < MAX_LANES; k++) begin
            lane_en[k] = (k < (MAX_LANES >> width_i));
        end
    end

    // One bank per lane width; narrower flag vectors are zero-extended.
    for (genvar gw = 0; gw < NUM_WIDTHS; gw++) begin : g_width
        localparam int LW = MIN_LANE_W << gw;
        localparam int NL = DATA_W / LW;
        logic [NL*FLAG_BITS-1:0] flg_small;

        simd_lane_bank #(.DATA_W(DATA_W), .LANE_W(LW)) u_bank (
            .op    (op),
            .sat   (sat_i),
            .sgn   (signed_i),
            .cond  (cond_sel[NL-1:0]),
            .a     (a_i),
            .b     (b_i),
            .c     (c_i),
            .res   (bank_res[gw]),
            .flags (flg_small)
        );

        assign bank_flg[gw] = FLAG_W'(flg_small);
    end

    // Width select across the banks.
    always_comb begin
        res_mux = '0;
        flg_mux = '0;
        for (int g = 0; g < NUM_WIDTHS; g++) begin
            if (int'(width_i) == g) begin
                res_mux = bank_res[g];
                flg_mux = bank_flg[g];
            end
        end
    end

    simd_flag_regs #(.N_SETS(MAX_LANES)) u_flags (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (valid_i && setf_i),
        .lane_en (lane_en),
        .d       (flg_mux),
        .q       (flag_q)
    );

    // Output stage: one-cycle result register with valid.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= 1'b0;
            res_q   <= '0;
        end else begin
            valid_q <= valid_i;
            if (valid_i) begin
                res_q <= res_mux;
            end
        end
    end

    assign valid_o = valid_q;
    assign res_o   = res_q;
    assign flags_o = flag_q;

endmodule

// File: rtl/simd_subword_alu_chk.sv
// Module: cycle-level property checker for simd_subword_alu, bound below.
// Assumes the default 64-bit data width with 8-bit minimum lanes.
module simd_subword_alu_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        valid_i,
    input logic [2:0]  op_i,
    input logic [1:0]  width_i,
    input logic        signed_i,
    input logic        setf_i,
    input logic [63:0] a_i,
    input logic [63:0] b_i,
    input logic        valid_o,
    input logic [63:0] res_o,
    input logic [31:0] flags_o
);
    // True when every byte is either all zeros or all ones.
    function automatic logic byte_masks(input logic [63:0] x);
        logic ok;
        ok = 1'b1;
        for (int i = 0; i < 8; i++) begin
            if (x[i*8 +: 8] != 8'h00 && x[i*8 +: 8] != 8'hFF) ok = 1'b0;
        end
        return ok;
    endfunction

    assert_valid_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
        valid_i |=> valid_o);

    assert_valid_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_i |=> !valid_o);

    assert_flags_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(valid_i && setf_i) |=> $stable(flags_o));

    assert_cmp_mask_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && op_i == 3'd2 && width_i == 2'd0) |=> byte_masks(res_o));

    assert_max_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && op_i == 3'd4 && width_i == 2'd3 && !signed_i)
        |=> (res_o >= $past(a_i)) && (res_o >= $past(b_i)));

    assert_cmov_source_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && op_i == 3'd6 && width_i == 2'd3)
        |=> (res_o == $past(a_i)) || (res_o == $past(b_i)));

endmodule

bind simd_subword_alu simd_subword_alu_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .valid_i  (valid_i),
    .op_i     (op_i),
    .width_i  (width_i),
    .signed_i (signed_i),
    .setf_i   (setf_i),
    .a_i      (a_i),
    .b_i      (b_i),
    .valid_o  (valid_o),
    .res_o    (res_o),
    .flags_o  (flags_o)
);

// File: tb/simd_subword_alu_tb.sv
// Scoreboard bench: the driver computes expected results with its own lane
// model and queues them; the monitor compares on each valid output.
module simd_subword_alu_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        valid_i = 1'b0;
    logic [2:0]  op_i = '0;
    logic [1:0]  width_i = '0;
    logic        sat_i = 1'b0;
    logic        signed_i = 1'b0;
    logic        setf_i = 1'b0;
    logic [1:0]  fsel_i = '0;
    logic [63:0] a_i = '0;
    logic [63:0] b_i = '0;
    logic [63:0] c_i = '0;
    logic        valid_o;
    logic [63:0] res_o;
    logic [31:0] flags_o;

    int n_checks = 0;
    int n_fail   = 0;
    logic [31:0] model_flags = '0;
    bit done = 1'b0;

    typedef struct {
        logic [63:0] res;
        logic [31:0] flg;
        string       tag;
    } exp_t;
    exp_t sb_q[$];

    always #5 clk = ~clk;

    simd_subword_alu u_dut (
        .clk(clk), .rst_n(rst_n), .valid_i(valid_i), .op_i(op_i),
        .width_i(width_i), .sat_i(sat_i), .signed_i(signed_i),
        .setf_i(setf_i), .fsel_i(fsel_i), .a_i(a_i), .b_i(b_i), .c_i(c_i),
        .valid_o(valid_o), .res_o(res_o), .flags_o(flags_o)
    );

    // Widen a lane value to a 66-bit signed number under the given view.
    function automatic logic signed [65:0] ext(input logic [63:0] x, input int lw, input logic s);
        logic signed [65:0] r;
        r = $signed({2'b00, x});
        if (s && x[lw-1]) r = r - (66'sd1 <<< lw);
        return r;
    endfunction

    // Reference model for one lane.
    task automatic model_lane(input int lw, input logic [2:0] op, input logic sat,
                              input logic s, input logic flag,
                              input logic [63:0] a, input logic [63:0] b, input logic [63:0] c,
                              output logic [63:0] r, output logic [3:0] f);
        logic [63:0] mask;
        logic signed [65:0] ea, eb, ec, e, lo, hi;
        logic sub, arith, gt;
        logic [64:0] raw;
        mask  = (lw == 64) ? '1 : ((64'd1 << lw) - 1);
        ea = ext(a, lw, s); eb = ext(b, lw, s); ec = ext(c, lw, s);
        gt    = ea > eb;
        sub   = (op == 3'd1) || (op == 3'd7 && !flag);
        arith = (op == 3'd0) || (op == 3'd1) || (op == 3'd7);
        raw   = {1'b0, a} + {1'b0, (sub ? ~b : b) & mask} + 65'(sub);
        case (op)
            3'd2: r = gt ? mask : 64'd0;
            3'd3: r = gt ? b : a;
            3'd4: r = gt ? a : b;
            3'd5: begin
                e = (eb > ea) ? eb : ea;
                e = (e > ec) ? ec : e;
                r = e[63:0] & mask;
            end
            3'd6: r = flag ? b : a;
            default: begin
                e  = sub ? ea - eb : ea + eb;
                lo = s ? -(66'sd1 <<< (lw - 1)) : 66'sd0;
                hi = s ? ((66'sd1 <<< (lw - 1)) - 1) : $signed({2'b00, mask});
                if (sat && e < lo) e = lo;
                if (sat && e > hi) e = hi;
                r = e[63:0] & mask;
            end
        endcase
        f[0] = (r == 64'd0);
        f[1] = r[lw-1];
        f[2] = arith && raw[lw];
        f[3] = gt;
    endtask

    // Driver: issue one operation and queue its expected outcome.
    task automatic issue(input logic [2:0] op, input logic [1:0] w, input logic sat,
                         input logic s, input logic setf, input logic [1:0] fsel,
                         input logic [63:0] a, input logic [63:0] b, input logic [63:0] c,
                         input string tag);
        exp_t e;
        int lw, nl;
        logic [63:0] mask, la, lb, lc, lr;
        logic [3:0] lf;
        logic [31:0] nf;
        lw = 8 << w; nl = 8 >> w;
        mask = (lw == 64) ? '1 : ((64'd1 << lw) - 1);
        e.res = '0;
        nf = model_flags;
        for (int k = 0; k < nl; k++) begin
            la = (a >> (k * lw)) & mask;
            lb = (b >> (k * lw)) & mask;
            lc = (c >> (k * lw)) & mask;
            model_lane(lw, op, sat, s, model_flags[4*k + int'(fsel)], la, lb, lc, lr, lf);
            e.res = e.res | (lr << (k * lw));
            if (setf) nf[4*k +: 4] = lf;
        end
        model_flags = nf;
        e.flg = nf;
        e.tag = tag;
        @(negedge clk);
        valid_i = 1'b1; op_i = op; width_i = w; sat_i = sat; signed_i = s;
        setf_i = setf; fsel_i = fsel; a_i = a; b_i = b; c_i = c;
        sb_q.push_back(e);
    endtask

    task automatic idle(input int n);
        @(negedge clk);
        valid_i = 1'b0;
        repeat (n) @(negedge clk);
    endtask

    // Monitor: compare each valid result and the flags against the queue.
    always @(negedge clk) begin
        exp_t e;
        if (rst_n && valid_o && !done) begin
            n_checks++;
            if (sb_q.size() == 0) begin
                n_fail++;
                $display("FAIL R2 unexpected valid_o: act=1 exp=0");
            end else begin
                e = sb_q.pop_front();
                if (res_o !== e.res) begin
                    n_fail++;
                    $display("FAIL %s result: act=%h exp=%h", e.tag, res_o, e.res);
                end
                n_checks++;
                if (flags_o !== e.flg) begin
                    n_fail++;
                    $display("FAIL %s flags: act=%h exp=%h", e.tag, flags_o, e.flg);
                end
            end
        end
    end

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL R2 watchdog: act=hung exp=finished");
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        // R12: reset state, inputs held active to prove they are ignored.
        repeat (3) @(negedge clk);
        valid_i = 1'b1; setf_i = 1'b1; a_i = 64'h1234; b_i = 64'h1;
        @(negedge clk);
        n_checks++;
        if (valid_o !== 1'b0 || res_o !== 64'd0 || flags_o !== 32'd0) begin
            n_fail++;
            $display("FAIL R12 reset state: act=%b/%h/%h exp=0/0/0", valid_o, res_o, flags_o);
        end
        valid_i = 1'b0; setf_i = 1'b0; a_i = '0; b_i = '0;
        rst_n = 1'b1;
        @(negedge clk);
        n_checks++;
        if (valid_o !== 1'b0) begin
            n_fail++;
            $display("FAIL R2 idle valid: act=%b exp=0", valid_o);
        end

        // R1 R3: modulo add and subtract at every width
        issue(3'd0, 2'd0, 0, 0, 1, 0, 64'h7F80_FF01_1020_30FF, 64'h0180_0101_F0E0_D001, 0, "R3 add8");
        issue(3'd1, 2'd1, 0, 0, 1, 0, 64'h0000_8000_1234_0005, 64'h0001_0001_1234_0007, 0, "R3 sub16");
        issue(3'd0, 2'd2, 0, 1, 1, 0, 64'hFFFF_FFFF_7FFF_FFFF, 64'h0000_0001_0000_0001, 0, "R1 add32");
        issue(3'd1, 2'd3, 0, 0, 1, 0, 64'd5, 64'd9, 0, "R1 sub64");
        // R4: saturation, signed and unsigned
        issue(3'd0, 2'd0, 1, 1, 1, 0, 64'h7F80_7F80_0102_C0C0, 64'h0101_80FF_0102_C0C0, 0, "R4 sadd8");
        issue(3'd0, 2'd0, 1, 0, 1, 0, 64'hFF80_0101_F0E0_1234, 64'h0180_FEFF_2020_1234, 0, "R4 uadd8");
        issue(3'd1, 2'd1, 1, 0, 1, 0, 64'h0005_FFFF_0000_8000, 64'h0009_0001_0001_8000, 0, "R4 usub16");
        issue(3'd1, 2'd3, 1, 1, 1, 0, 64'h8000_0000_0000_0000, 64'd1, 0, "R4 ssub64");
        // R5 R9: compare sets flags under both signedness views
        issue(3'd2, 2'd0, 0, 1, 1, 0, 64'h80_7F_01_00_FF_10_20_05, 64'h7F_80_00_01_01_10_10_06, 0, "R5 scmp8");
        // R10: guarded move on compare-true flags from the previous compare
        issue(3'd6, 2'd0, 0, 0, 0, 2'd3, 64'h1111_1111_1111_1111, 64'h2222_2222_2222_2222, 0, "R10 cmov8");
        issue(3'd2, 2'd0, 0, 0, 1, 0, 64'h80_7F_01_00_FF_10_20_05, 64'h7F_80_00_01_01_10_10_06, 0, "R5 ucmp8");
        // R8: a write with 32-bit lanes keeps sets 2..7; no-write op keeps all
        issue(3'd0, 2'd2, 0, 0, 1, 0, 64'd0, 64'd0, 0, "R8 narrow set write");
        issue(3'd1, 2'd0, 0, 0, 0, 0, 64'd0, 64'd1, 0, "R8 no flag write");
        // R10: guarded move on zero flags with 16-bit lanes
        issue(3'd6, 2'd1, 0, 0, 0, 2'd0, 64'hAAAA_BBBB_CCCC_DDDD, 64'h1111_2222_3333_4444, 0, "R10 cmov16");
        // R11: steered add-or-subtract
        issue(3'd2, 2'd1, 0, 1, 1, 0, 64'h0010_FFF0_0005_0000, 64'h0001_0000_0005_8000, 0, "R5 cmp16");
        issue(3'd7, 2'd1, 0, 0, 0, 2'd3, 64'h0100_0100_0100_0100, 64'h0003_0003_0003_0003, 0, "R11 addsub16");
        issue(3'd7, 2'd0, 1, 0, 1, 2'd3, 64'hFFFF_FFFF_0000_0000, 64'h0101_0101_0101_0101, 0, "R11 addsub8 sat");
        // R6 R7: min, max, clamp
        issue(3'd3, 2'd0, 0, 1, 0, 0, 64'h80_7F_05_FE_00_10_20_30, 64'h7F_80_06_02_00_11_1F_30, 0, "R6 smin8");
        issue(3'd4, 2'd0, 0, 0, 1, 0, 64'h80_7F_05_FE_00_10_20_30, 64'h7F_80_06_02_00_11_1F_30, 0, "R6 umax8");
        issue(3'd5, 2'd1, 0, 1, 0, 0, 64'hFF00_0050_0010_0005, 64'hFFF0_0000_0020_0010, 64'h0010_0040_0030_0000, "R7 sclip16");
        issue(3'd5, 2'd2, 0, 0, 1, 0, 64'h0000_0005_9000_0000, 64'h0000_0010_0000_0001, 64'h0000_0100_7000_0000, "R7 uclip32");
        idle(2);
        // R2: back-to-back mixed stream from a pseudo-random source
        for (int i = 0; i < 40; i++) begin
            issue(3'($urandom_range(0, 7)), 2'($urandom_range(0, 3)), 1'($urandom_range(0, 1)),
                  1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)), 2'($urandom_range(0, 3)),
                  {$urandom, $urandom}, {$urandom, $urandom}, {$urandom, $urandom}, "R2 mixed stream");
        end
        idle(4);
        done = 1'b1;
        n_checks++;
        if (sb_q.size() != 0) begin
            n_fail++;
            $display("FAIL R2 missing results: act=%0d exp=0", sb_q.size());
        end
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

endmodule